// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Controller

This block watches one asynchronous external pin and raises an interrupt request toward a CPU core when a chosen transition appears on it. A two-bit mode field selects rising edges, falling edges or any level change, and a fourth code turns detection off. A detected edge latches a pending flag whether or not the source is enabled. Software reads the flag and clears it through a small register port.

An interrupt-entry request with a fixed vector address is asserted while the pending flag, the source enable and the global enable are all 1. The cycle the request is seen counts as entry. At that point the global enable drops, so the handler cannot be re-entered. A return-from-interrupt strobe sets the global enable again. The pending flag is never cleared by hardware; software clears it by writing 0.

Register map (2-bit address, 8-bit data): address 0 is the control register, with the mode field in bits [4:3] and all other bits reading 0. Address 1 bit 0 is the pending flag. Address 2 bit 0 is the source enable. Address 3 bit 0 is the global enable. Unused bits read 0.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the mode field is 2'b10 (control register reads 8'h10), and the pending flag, source enable and global enable all read 0.
- R2: With mode 2'b01, a low-to-high pin transition sets the pending flag and a high-to-low transition does not.
- R3: With mode 2'b10, a high-to-low pin transition sets the pending flag and a low-to-high transition does not.
- R4: With mode 2'b11, either pin transition sets the pending flag.
- R5: With mode 2'b00, no pin transition sets the pending flag.
- R6: The flag goes high at the third rising clock edge after the pin changes (two synchronizer stages plus the flag register). It does so even when the source enable is 0.
- R7: irq_req_o is 1 exactly when the flag, the source enable and the global enable are all 1. While it is 1, irq_vec_o equals 8.
- R8: In the cycle after irq_req_o is 1, the global enable reads 0 and the pending flag is still 1.
- R9: A one-cycle pulse on reti_i sets the global enable at the next clock edge.
- R10: Writing address 1 with bit 0 = 0 clears the flag. Writing it with bit 0 = 1 leaves the flag unchanged.
- R11: If a flag clear and a qualifying edge fall in the same cycle, the flag is 1 afterwards.
- R12: Writes to control bits other than [4:3] have no effect, and those bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_req_o | output | 1 | Interrupt-entry request |
| irq_vec_o | output | 8 | Vector address for entry |

## Verification
A pin change driven between clock edges shows up in the pending flag after exactly three rising edges. The bench samples at the falling edge after the third rising edge, and also one edge earlier to confirm the flag is not set too soon. Register writes take effect at the single rising edge inside the write task, so read-backs are sampled at the falling edge that follows. The entry request follows the three enables combinationally and is checked at that same falling edge. The global-enable drop and the reti_i restore are each checked one edge later. The same-cycle clear test times the write so that it lands on the edge where the synchronized edge is present.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  localparam int          ADDR_W   = 2;
  localparam int          DATA_W   = 8;
  localparam int          MODE_LSB = 3;
  localparam edge_mode_e  MODE_RST = EDGE_FALL;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_FLAG  = 2'd1;
  localparam logic [ADDR_W-1:0] A_SRCEN = 2'd2;
  localparam logic [ADDR_W-1:0] A_GIE   = 2'd3;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/eirq_edge_det.sv
module eirq_edge_det
  import eirq_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  edge_mode_e mode_i,
  output logic       hit_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_ANY:  hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hit_i,
  input  logic              take_i,
  input  logic              reti_i,
  output edge_mode_e        mode_o,
  output logic              flag_o,
  output logic              src_en_o,
  output logic              gie_o,
  output logic [DATA_W-1:0] rdata_o
);
  edge_mode_e mode_q;
  logic       flag_q, src_en_q, gie_q;
  logic       wr_ctrl, wr_flag, wr_src, wr_gie;

  assign wr_ctrl = we_i && (addr_i == A_CTRL);
  assign wr_flag = we_i && (addr_i == A_FLAG);
  assign wr_src  = we_i && (addr_i == A_SRCEN);
  assign wr_gie  = we_i && (addr_i == A_GIE);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      mode_q <= MODE_RST;
    else if (wr_ctrl) mode_q <= edge_mode_e'(wdata_i[MODE_LSB+:2]);

  // new edge beats a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                    flag_q <= 1'b0;
    else if (hit_i)                 flag_q <= 1'b1;
    else if (wr_flag && !wdata_i[0]) flag_q <= 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     src_en_q <= 1'b0;
    else if (wr_src) src_en_q <= wdata_i[0];

  // entry masks further requests until return
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      gie_q <= 1'b0;
    else if (take_i)  gie_q <= 1'b0;
    else if (reti_i)  gie_q <= 1'b1;
    else if (wr_gie)  gie_q <= wdata_i[0];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:  rdata_o[MODE_LSB+:2] = mode_q;
      A_FLAG:  rdata_o[0] = flag_q;
      A_SRCEN: rdata_o[0] = src_en_q;
      default: rdata_o[0] = gie_q;
    endcase
  end

  assign mode_o   = mode_q;
  assign flag_o   = flag_q;
  assign src_en_o = src_en_q;
  assign gie_o    = gie_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_RST     = 1'b0,
  parameter int   VEC_W       = 8,
  parameter int   VECTOR      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              reti_i,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  logic       pin_s, edge_hit;
  logic       flag_q, src_en_q, gie_q;
  edge_mode_e edge_mode;

  eirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
  );

  eirq_edge_det #(.RST_VAL(PIN_RST)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(pin_s), .mode_i(edge_mode), .hit_o(edge_hit)
  );

  eirq_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .hit_i(edge_hit), .take_i(irq_req_o), .reti_i(reti_i),
    .mode_o(edge_mode), .flag_o(flag_q), .src_en_o(src_en_q), .gie_o(gie_q),
    .rdata_o(reg_rdata_o)
  );

  assign irq_req_o = flag_q & src_en_q & gie_q;
  assign irq_vec_o = VEC_W'(VECTOR);
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       irq_req_i,
  input logic [7:0] irq_vec_i,
  input logic       reti_i,
  input logic       gie_i,
  input logic       flag_i,
  input logic       hit_i,
  input logic [1:0] mode_i,
  input logic       we_i,
  input logic [1:0] addr_i,
  input logic [7:0] wdata_i
);
  a_r8_entry_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_i |=> !gie_i);
  a_r8_flag_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_i |=> flag_i);
  a_r9_reti_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !irq_req_i) |=> gie_i);
  a_r11_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> flag_i);
  a_r10_clear_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_i) |-> $past(we_i && addr_i == 2'd1 && !wdata_i[0]));
  a_r6_set_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(hit_i));
  a_r5_off_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |-> !hit_i);
  a_r7_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_i |-> irq_vec_i == 8'd8);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_req_i(irq_req_o), .irq_vec_i(irq_vec_o),
  .reti_i(reti_i), .gie_i(gie_q), .flag_i(flag_q), .hit_i(edge_hit),
  .mode_i(edge_mode), .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i)
);

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       reti = 1'b0;
  logic       req;
  logic [7:0] vec;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  ext_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reti_i(reti),
    .irq_req_o(req), .irq_vec_o(vec)
  );

  // {mode[1:0], pin_before, pin_after, expect_flag}
  localparam logic [4:0] VEC [8] = '{
    5'b01_01_1, 5'b01_10_0,   // R2
    5'b10_01_0, 5'b10_10_1,   // R3
    5'b11_01_1, 5'b11_10_1,   // R4
    5'b00_01_0, 5'b00_10_0    // R5
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [7:0] d;
    cyc(2);
    rd(2'd0, d); chk("R1 ctrl", d, 8'h10);
    rd(2'd1, d); chk("R1 flag", d, 8'h00);
    rd(2'd2, d); chk("R1 srcen", d, 8'h00);
    rd(2'd3, d); chk("R1 gie", d, 8'h00);
    chk("R1 req", {7'd0, req}, 8'h00);
    rst_n = 1'b1;
    cyc(2);

    for (int i = 0; i < 8; i++) begin
      wr(2'd0, {3'b000, VEC[i][4:3], 3'b000});
      pin = VEC[i][2];
      cyc(4);
      wr(2'd1, 8'h00);
      pin = VEC[i][1];
      cyc(3);
      rd(2'd1, d);
      chk($sformatf("R2-5 vector %0d", i), d, {7'd0, VEC[i][0]});
    end

    // R6 latency, source disabled
    wr(2'd0, 8'h08); pin = 1'b0; cyc(4); wr(2'd1, 8'h00);
    pin = 1'b1;
    cyc(2); rd(2'd1, d); chk("R6 early", d, 8'h00);
    cyc(1); rd(2'd1, d); chk("R6 on time", d, 8'h01);
    chk("R7 no req when disabled", {7'd0, req}, 8'h00);

    // R10 write 1 keeps, write 0 clears
    wr(2'd1, 8'h01); rd(2'd1, d); chk("R10 write one", d, 8'h01);
    wr(2'd1, 8'hFE); rd(2'd1, d); chk("R10 write zero", d, 8'h00);

    // R12 stray control bits
    wr(2'd0, 8'hE7 | 8'h08); rd(2'd0, d); chk("R12 ctrl bits", d, 8'h08);

    // R11 clear coinciding with edge (mode rise)
    pin = 1'b0; cyc(4); pin = 1'b1; cyc(4);
    rd(2'd1, d); chk("R11 pre set", d, 8'h01);
    pin = 1'b0; cyc(4);
    pin = 1'b1; cyc(2);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R11 edge wins", d, 8'h01);

    // R7/R8/R9 entry flow, flag pending
    wr(2'd3, 8'h01);
    chk("R7 gie only", {7'd0, req}, 8'h00);
    wr(2'd2, 8'h01);
    chk("R7 req", {7'd0, req}, 8'h01);
    chk("R7 vector", vec, 8'd8);
    cyc(1);
    chk("R8 req drop", {7'd0, req}, 8'h00);
    rd(2'd3, d); chk("R8 gie cleared", d, 8'h00);
    rd(2'd1, d); chk("R8 flag kept", d, 8'h01);
    cyc(2);
    chk("R8 stays masked", {7'd0, req}, 8'h00);
    reti = 1'b1; cyc(1); reti = 1'b0;
    chk("R9 reti reenables", {7'd0, req}, 8'h01);
    cyc(1);
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h01);
    rd(2'd3, d); chk("R9 gie by write", d, 8'h01);
    chk("R7 no flag no req", {7'd0, req}, 8'h00);

    summary();
  end
endmodule